// File: doc/BRIEF.md
# Credit-Gated Packet Sender with Header Retry

This block is the transmit end of a point-to-point packet link. Packets from local requesters are held in a small pool of send buffers, and each gets a wrapping sequence number. A packet goes onto the link only while the far end has a free receive buffer. The sender tracks those free buffers as a credit count. The far end talks back through short link control words (LCWs). An LCW can grant credits, acknowledge headers up to a given sequence number, report a damaged header, or report a damaged payload.

A send buffer stays occupied until the header it carries is acknowledged. An acknowledgement is cumulative and frees every held packet up to and including the named one. A header-error report rewinds the transmit pointer, so the named packet and every later one that was already sent go out again in order. They go out ahead of any packet that has never been sent. A payload-error report never causes a resend. The block only raises a one-cycle notice that carries the originator id taken from the far end's report. Byte framing, parity and check fields belong to a later stage, so each transmitted packet appears here as a single registered word with its sequence number and originator id.

Top module: `creditRetrySender`

## Requirements
- R1: After reset, txValid and errValid are 0, inReady is 1, the credit count equals INIT_CREDITS, and the first packet accepted gets sequence number 0.
- R2: A packet is transmitted only while the credit count is non-zero, and each transmission, including a resend, uses one credit. An LCW of kind 0 adds lcwArg to the count, and the count saturates at MAX_CREDITS.
- R3: The pool holds four packets. inReady is 0 while four packets are unacknowledged, and an inValid pulse in that state is ignored.
- R4: An LCW of kind 1 with sequence N (lcwArg[2:0]) frees every held packet from the oldest one up to and including N.
- R5: An LCW of kind 2 with sequence N makes the sender transmit N and every later packet already sent, again and in order, before any packet that has never been sent.
- R6: An LCW of kind 3 sets errValid for exactly the next cycle, with errSrc equal to lcwArg[3:0]. It causes no resend and leaves the buffers and pointers unchanged.
- R7: Sequence numbers go up by one per accepted packet, modulo 8. A transmission appears on txValid/txSeq/txData/txSrc one cycle after the cycle in which it was chosen, and it carries the stored data and originator of that sequence number.
- R8: A kind 1 or kind 2 LCW whose sequence number is not among the packets sent but not yet acknowledged is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Offer a new packet |
| inData | input | DATA_W | Packet word |
| inSrc | input | SRC_W | Originator id of the packet |
| inReady | output | 1 | A send buffer is free |
| lcwValid | input | 1 | A link control word is present |
| lcwKind | input | 2 | 0 credit, 1 ack, 2 header error, 3 payload error |
| lcwArg | input | ARG_W | Credit amount, sequence number (low 3 bits) or originator id (low SRC_W bits) |
| txValid | output | 1 | A packet is on the link this cycle |
| txSeq | output | 3 | Sequence number of the transmitted packet |
| txData | output | DATA_W | Word of the transmitted packet |
| txSrc | output | SRC_W | Originator of the transmitted packet |
| errValid | output | 1 | Payload-error notice |
| errSrc | output | SRC_W | Originator named in the payload-error notice |

## Verification
The bench goes after credit exhaustion and oversized credit grants. A counter that does not saturate would send a packet that the bench expects to wait for a later grant. It also checks a full pool receiving a stray acknowledgement for a sequence number that was never sent. A design that trusted that acknowledgement would raise inReady too early and overwrite a buffer that is still held. A header error is injected while unsent packets are queued behind the damaged one, so a design that did not rewind, or that sent the new packets first, shows the wrong txSeq order. Sequence wrap from 7 to 0 and payload-error notices are covered as well, and a long pseudo-random run is compared cycle by cycle against a behavioural model.

// File: rtl/creditSenderPkg.sv
package creditSenderPkg;
  localparam int SEQ_W = 3;
  localparam int IDX_W = SEQ_W - 1;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {
    LCW_CREDIT  = 2'd0,
    LCW_ACK     = 2'd1,
    LCW_HDR_ERR = 2'd2,
    LCW_PAY_ERR = 2'd3
  } lcwKind_e;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             txLoad;
    logic [IDX_W-1:0] rdIdx;
    logic [SEQ_W-1:0] txSeq;
    logic             errLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/senderCtrl.sv
module senderCtrl
  import creditSenderPkg::*;
#(
  parameter int ARG_W        = 8,
  parameter int INIT_CREDITS = 2,
  parameter int MAX_CREDITS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             lcwValid,
  input  logic [1:0]       lcwKind,
  input  logic [ARG_W-1:0] lcwArg,
  output ctlStrobe_t       strobe
);
  localparam int CRED_W = $clog2(MAX_CREDITS + 1);
  localparam int SUM_W  = ((ARG_W > CRED_W) ? ARG_W : CRED_W) + 1;

  logic [SEQ_W-1:0]  headSeq, sendSeq, tailSeq;
  logic [CRED_W-1:0] credits, credNext;
  logic [SEQ_W-1:0]  heldCnt, sentCnt, argSeq, argOff;
  logic [SUM_W-1:0]  credSum;
  logic              canSend, doEnq, argInFlight;
  logic              isCredit, isAck, isHdrErr, isPayErr;

  // occupancy and in-flight window, all modulo the sequence space
  assign heldCnt     = tailSeq - headSeq;
  assign sentCnt     = sendSeq - headSeq;
  assign argSeq      = lcwArg[SEQ_W-1:0];
  assign argOff      = argSeq - headSeq;
  assign argInFlight = argOff < sentCnt;

  assign isCredit = lcwValid && (lcwKind == LCW_CREDIT);
  assign isAck    = lcwValid && (lcwKind == LCW_ACK);
  assign isHdrErr = lcwValid && (lcwKind == LCW_HDR_ERR);
  assign isPayErr = lcwValid && (lcwKind == LCW_PAY_ERR);

  assign inReady = heldCnt < SEQ_W'(DEPTH);
  assign doEnq   = inValid && inReady;
  assign canSend = (sendSeq != tailSeq) && (credits != '0);

  // credit update: spend one per transmission, add grants, clip at maximum
  always_comb begin
    credSum = SUM_W'(credits) - SUM_W'(canSend) + (isCredit ? SUM_W'(lcwArg) : '0);
    if (credSum > SUM_W'(MAX_CREDITS)) credNext = CRED_W'(MAX_CREDITS);
    else                               credNext = credSum[CRED_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headSeq <= '0;
      sendSeq <= '0;
      tailSeq <= '0;
      credits <= CRED_W'(INIT_CREDITS);
    end else begin
      credits <= credNext;
      if (doEnq) tailSeq <= tailSeq + SEQ_W'(1);
      if (isAck && argInFlight) headSeq <= argSeq + SEQ_W'(1);
      // a rewind wins over the normal advance of the send pointer
      if (isHdrErr && argInFlight) sendSeq <= argSeq;
      else if (canSend)            sendSeq <= sendSeq + SEQ_W'(1);
    end
  end

  always_comb begin
    strobe.wrEn    = doEnq;
    strobe.wrIdx   = tailSeq[IDX_W-1:0];
    strobe.txLoad  = canSend;
    strobe.rdIdx   = sendSeq[IDX_W-1:0];
    strobe.txSeq   = sendSeq;
    strobe.errLoad = isPayErr;
  end
endmodule

// File: rtl/senderData.sv
module senderData
  import creditSenderPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [SRC_W-1:0]  inSrc,
  input  logic [SRC_W-1:0]  errSrcIn,
  output logic              txValid,
  output logic [SEQ_W-1:0]  txSeq,
  output logic [DATA_W-1:0] txData,
  output logic [SRC_W-1:0]  txSrc,
  output logic              errValid,
  output logic [SRC_W-1:0]  errSrc
);
  logic [DATA_W-1:0] memData [DEPTH];
  logic [SRC_W-1:0]  memSrc  [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      memData[strobe.wrIdx] <= inData;
      memSrc[strobe.wrIdx]  <= inSrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid  <= 1'b0;
      txSeq    <= '0;
      txData   <= '0;
      txSrc    <= '0;
      errValid <= 1'b0;
      errSrc   <= '0;
    end else begin
      txValid  <= strobe.txLoad;
      errValid <= strobe.errLoad;
      if (strobe.txLoad) begin
        txSeq  <= strobe.txSeq;
        txData <= memData[strobe.rdIdx];
        txSrc  <= memSrc[strobe.rdIdx];
      end
      if (strobe.errLoad) errSrc <= errSrcIn;
    end
  end
endmodule

// File: rtl/creditRetrySender.sv
module creditRetrySender
  import creditSenderPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SRC_W        = 4,
  parameter int ARG_W        = 8,
  parameter int INIT_CREDITS = 2,
  parameter int MAX_CREDITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [SRC_W-1:0]  inSrc,
  output logic              inReady,
  input  logic              lcwValid,
  input  logic [1:0]        lcwKind,
  input  logic [ARG_W-1:0]  lcwArg,
  output logic              txValid,
  output logic [SEQ_W-1:0]  txSeq,
  output logic [DATA_W-1:0] txData,
  output logic [SRC_W-1:0]  txSrc,
  output logic              errValid,
  output logic [SRC_W-1:0]  errSrc
);
  ctlStrobe_t strobe;

  senderCtrl #(
    .ARG_W(ARG_W), .INIT_CREDITS(INIT_CREDITS), .MAX_CREDITS(MAX_CREDITS)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .lcwValid(lcwValid), .lcwKind(lcwKind), .lcwArg(lcwArg), .strobe(strobe)
  );

  senderData #(.DATA_W(DATA_W), .SRC_W(SRC_W)) dataI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inSrc(inSrc),
    .errSrcIn(lcwArg[SRC_W-1:0]), .txValid(txValid), .txSeq(txSeq),
    .txData(txData), .txSrc(txSrc), .errValid(errValid), .errSrc(errSrc)
  );
endmodule

// File: rtl/creditRetrySenderChecker.sv
module creditRetrySenderChecker
  import creditSenderPkg::*;
#(
  parameter int SRC_W = 4,
  parameter int ARG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             lcwValid,
  input logic [1:0]       lcwKind,
  input logic [ARG_W-1:0] lcwArg,
  input logic             txValid,
  input logic [SEQ_W-1:0] txSeq,
  input logic             errValid,
  input logic [SRC_W-1:0] errSrc
);
  logic hdrErrIn, payErrIn, ackIn;
  assign hdrErrIn = lcwValid && (lcwKind == 2'd2);
  assign payErrIn = lcwValid && (lcwKind == 2'd3);
  assign ackIn    = lcwValid && (lcwKind == 2'd1);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!txValid && inReady && !errValid));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !ackIn) |=> !inReady);

  assert_free_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> inReady);

  assert_pay_notice_R6: assert property (@(posedge clk) disable iff (!rstN)
    payErrIn |=> (errValid && errSrc == $past(lcwArg[SRC_W-1:0])));

  assert_pay_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !payErrIn |=> !errValid);

  assert_seq_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && $past(txValid) && !$past(hdrErrIn, 2))
      |-> (txSeq == SEQ_W'($past(txSeq) + SEQ_W'(1))));
endmodule

bind creditRetrySender creditRetrySenderChecker #(.SRC_W(SRC_W), .ARG_W(ARG_W)) chkI (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .lcwValid(lcwValid), .lcwKind(lcwKind), .lcwArg(lcwArg),
  .txValid(txValid), .txSeq(txSeq), .errValid(errValid), .errSrc(errSrc)
);

// File: tb/creditRetrySender_tb_top.sv
module creditRetrySender_tb_top;
  localparam int DW = 16, SW = 4, AW = 8, INITC = 2, MAXC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [SW-1:0] inSrc = '0;
  logic inReady;
  logic lcwValid = 1'b0;
  logic [1:0] lcwKind = '0;
  logic [AW-1:0] lcwArg = '0;
  logic txValid, errValid;
  logic [2:0] txSeq;
  logic [DW-1:0] txData;
  logic [SW-1:0] txSrc, errSrc;

  always #10 clk = ~clk;

  creditRetrySender #(.DATA_W(DW), .SRC_W(SW), .ARG_W(AW),
    .INIT_CREDITS(INITC), .MAX_CREDITS(MAXC)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSrc(inSrc),
    .inReady(inReady), .lcwValid(lcwValid), .lcwKind(lcwKind), .lcwArg(lcwArg),
    .txValid(txValid), .txSeq(txSeq), .txData(txData), .txSrc(txSrc),
    .errValid(errValid), .errSrc(errSrc));

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  int txLog[$];

  // behavioural reference: unbounded counters and per-sequence storage
  int mHead = 0, mSend = 0, mTail = 0, mCred = INITC;
  int mData[8], mSrc[8];
  bit eTxValid = 0, eErr = 0, eReady = 1;
  int eTxSeq = 0, eTxData = 0, eTxSrc = 0, eErrSrc = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(bit iv, int d, int s, bit lv, int lk, int la);
    int sentC, off, newSend, newCred;
    bit can;
    sentC = mSend - mHead;
    can = (mSend < mTail) && (mCred > 0);
    eTxValid = can;
    if (can) begin
      eTxSeq = mSend % 8; eTxData = mData[mSend % 8]; eTxSrc = mSrc[mSend % 8];
    end
    newSend = can ? mSend + 1 : mSend;
    newCred = can ? mCred - 1 : mCred;
    if (iv && (mTail - mHead) < 4) begin
      mData[mTail % 8] = d; mSrc[mTail % 8] = s; mTail++;
    end
    eErr = 0;
    off = ((la % 8) - (mHead % 8) + 8) % 8;
    if (lv) begin
      case (lk)
        0: begin newCred += la; if (newCred > MAXC) newCred = MAXC; end
        1: if (off < sentC) mHead += off + 1;
        2: if (off < sentC) newSend = mHead + off;
        default: begin eErr = 1; eErrSrc = la % 16; end
      endcase
    end
    mSend = newSend; mCred = newCred;
    eReady = (mTail - mHead) < 4;
  endtask

  task automatic tick(bit iv, int d, int s, bit lv, int lk, int la);
    inValid = iv; inData = DW'(d); inSrc = SW'(s);
    lcwValid = lv; lcwKind = 2'(lk); lcwArg = AW'(la);
    @(posedge clk);
    modelStep(iv, d, s, lv, lk, la);
    @(negedge clk);
    chk("R2 txValid vs model", int'(txValid), int'(eTxValid));
    if (eTxValid) begin
      chk("R5 txSeq vs model", int'(txSeq), eTxSeq);
      chk("R7 txData vs model", int'(txData), eTxData);
      chk("R7 txSrc vs model", int'(txSrc), eTxSrc);
    end
    chk("R3 inReady vs model", int'(inReady), int'(eReady));
    chk("R6 errValid vs model", int'(errValid), int'(eErr));
    if (eErr) chk("R6 errSrc vs model", int'(errSrc), eErrSrc);
    if (txValid) txLog.push_back(int'(txSeq));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask
  task automatic enq(int d, int s);
    tick(1, d, s, 0, 0, 0);
  endtask
  task automatic lcw(int k, int a);
    tick(0, 0, 0, 1, k, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired (R1 run) actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int sz;
    lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R1 reset txValid", int'(txValid), 0);
    chk("R1 reset errValid", int'(errValid), 0);
    chk("R1 reset inReady", int'(inReady), 1);
    rstN = 1'b1;
    idle(2);

    // R2: two initial credits let only two of four packets go
    for (int i = 0; i < 4; i++) enq(16'hA0 + i, i + 1);
    idle(3);
    chk("R2 sends limited by credit", txLog.size(), 2);
    chk("R1 first seq is zero", txLog[0], 0);
    chk("R3 pool full", int'(inReady), 0);
    lcw(0, 1); idle(2);
    chk("R2 grant of one credit", txLog.size(), 3);
    chk("R7 third seq", txLog[2], 2);

    // R8 stray ack, R4 cumulative ack
    lcw(1, 6); idle(1);
    chk("R8 stray ack ignored", int'(inReady), 0);
    lcw(1, 1);
    chk("R4 cumulative ack frees", int'(inReady), 1);
    enq(16'hB4, 5); enq(16'hB5, 6);
    chk("R3 full again", int'(inReady), 0);

    // R5 rewind to 2 with seq 3..5 queued behind it
    lcw(2, 2);
    lcw(0, 7);
    idle(5);
    chk("R5 resend count", txLog.size(), 7);
    chk("R5 resend first", txLog[3], 2);
    chk("R5 then seq3", txLog[4], 3);
    chk("R5 then seq4", txLog[5], 4);
    chk("R5 then seq5", txLog[6], 5);

    // R2 saturation: grant of 7 was clipped to 4, all spent
    lcw(1, 5);
    enq(16'hC6, 7);
    idle(3);
    chk("R2 credit saturates", txLog.size(), 7);
    lcw(0, 1); idle(2);
    chk("R2 send after grant", txLog.size(), 8);

    // R6 payload error
    sz = txLog.size();
    lcw(3, 3);
    chk("R6 notice raised", int'(errValid), 1);
    chk("R6 notice source", int'(errSrc), 3);
    idle(1);
    chk("R6 notice one cycle", int'(errValid), 0);
    chk("R6 no resend", txLog.size(), sz);

    // R7 wrap through 7 -> 0
    lcw(1, 6);
    for (int k = 0; k < 4; k++) begin
      enq(16'hD0 + k, k);
      lcw(0, 1);
      idle(1);
      lcw(1, (7 + k) % 8);
    end
    chk("R7 seq 7", txLog[8], 7);
    chk("R7 wrap to 0", txLog[9], 0);
    chk("R7 seq 1", txLog[10], 1);
    chk("R7 seq 2", txLog[11], 2);

    // pseudo-random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r, k, a;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      r = lfsr & 32'h7fff_ffff;
      k = (r >> 4) % 4;
      case (k)
        0: a = (r >> 8) % 3;
        1, 2: a = (mHead + (r >> 8) % 5) % 8;
        default: a = (r >> 8) % 16;
      endcase
      tick((r % 3) != 0, (r >> 12) % 65536, (r >> 20) % 16, ((r >> 2) % 3) == 0, k, a);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule